// File: doc/BRIEF.md
# Serial Port Status and Interrupt Register Block

This block is the register side of a memory-mapped serial port. It stores the last received character and the character queued for sending. It keeps the receive, transmit and error status flags, and it drives one level interrupt line. A deserializer hands it received characters as single-cycle strobes with an optional framing-error mark. A serializer is given a one-cycle start pulse with the character to send, and it answers with a one-cycle done pulse. Baud timing and line coding live in those neighbours.

Software reaches the block over a 32-bit, word-only bus. Every access completes in one cycle, and read data is valid in the cycle the read strobe is high. Flags are cleared in three ways: a write-one-to-clear register, a request register whose flush bit drops the receive flag, and the side effect of reading received data. An overrun-disable control changes what happens when a character arrives before the previous one was read. The interrupt is a pure combination of flag and enable bits, so it drops in the same cycle the last active flag is cleared.

Top module: `uart_status_irq`

## Requirements
- R1: A received character is dropped (flags and received data unchanged) unless both control bit 0 (port enable) and control bit 1 (receive enable) are set.
- R2: With control bit 7 (overrun disable) clear, a character that arrives while status bit 5 (receive-not-empty) is set sets status bit 3 (overrun) and leaves the stored character unchanged.
- R3: With control bit 7 set, an arriving character always replaces the stored one and sets receive-not-empty, and overrun is not raised.
- R4: Reading offset 0x10 returns the stored 9-bit character zero-extended, and receive-not-empty is clear from the next cycle.
- R5: A write to offset 0x14 stores bits 8:0 and clears status bit 7 (transmit-empty). In the next cycle it pulses `tx_start` with that character, but only when control bit 2 (transmit enable) is set. A `tx_done` pulse sets transmit-empty and status bit 6 (transmission-complete).
- R6: A write to offset 0x08 clears each status bit whose position is written as 1; bits written as 0 keep their value.
- R7: Writing 1 to bit 3 at offset 0x0C clears receive-not-empty; reads of offsets 0x0C and 0x08 return zero.
- R8: `irq` is high whenever one of these enabled flag pairs is active, in the same cycle: receive-not-empty with control bit 3, transmit-empty with bit 4, transmission-complete with bit 5, overrun with bit 3 or bit 6, and framing error (status bit 1, set by an accepted character marked with `rx_frame_err`) with bit 6 only.
- R9: After reset the control register (offset 0x00) reads 0, the status register (offset 0x04) reads 0x020000C0, and the received data reads 0.
- R10: Writes to the status offset 0x04 and to the received-data offset 0x10 change nothing.
- R11: A write to any other offset changes nothing, and a read from it (including offsets that are not word aligned) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Received-character strobe from the deserializer |
| rx_char | input | CHAR_W | Received character |
| rx_frame_err | input | 1 | Framing error mark for the strobed character |
| tx_start | output | 1 | One-cycle start pulse to the serializer |
| tx_char | output | CHAR_W | Character to send |
| tx_done | input | 1 | Serializer finished the character |
| irq | output | 1 | Level interrupt |

## Verification
The checker assumes single-cycle strobes. It assumes no bus write lands in the same cycle as `tx_done`, and no read of the received-data offset lands in the same cycle as `rx_valid`. Its flag-stability and overrun properties rely on these assumptions, so both are written into their antecedents. The bench keeps to these rules by driving bus accesses, received characters and done pulses from separate tasks that run one after another. It never issues two of them in the same cycle. It also only pulses `tx_done` after a start was issued or while transmit is idle.

// File: rtl/uart_status_pkg.sv
// Package: offsets, status bit positions, control and flag types shared by
// the serial-port status block. Assumes word-aligned byte offsets.
package uart_status_pkg;

    localparam int BUS_W = 32;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_CLR  = 8'h08;
    localparam logic [7:0] OFF_REQ  = 8'h0C;
    localparam logic [7:0] OFF_RXD  = 8'h10;
    localparam logic [7:0] OFF_TXD  = 8'h14;

    localparam int POS_FE    = 1;
    localparam int POS_ORE   = 3;
    localparam int POS_RXNE  = 5;
    localparam int POS_TC    = 6;
    localparam int POS_TXE   = 7;
    localparam int POS_RDY   = 25;
    localparam int POS_FLUSH = 3;

    // Control word, bit 0 at the bottom.
    typedef struct packed {
        logic ovr_dis;
        logic err_ie;
        logic tc_ie;
        logic txe_ie;
        logic rxne_ie;
        logic tx_en;
        logic rx_en;
        logic port_en;
    } ctrl_t;

    typedef struct packed {
        logic rdy;
        logic txe;
        logic tc;
        logic rxne;
        logic ore;
        logic fe;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{rdy: 1'b1, txe: 1'b1, tc: 1'b1,
                                       rxne: 1'b0, ore: 1'b0, fe: 1'b0};

    // Place each flag at its status-word bit position.
    function automatic logic [BUS_W-1:0] stat_word(input flags_t f);
        logic [BUS_W-1:0] w;
        w           = '0;
        w[POS_FE]   = f.fe;
        w[POS_ORE]  = f.ore;
        w[POS_RXNE] = f.rxne;
        w[POS_TC]   = f.tc;
        w[POS_TXE]  = f.txe;
        w[POS_RDY]  = f.rdy;
        return w;
    endfunction

    // Gather the clear-mask bits that line up with the flags.
    function automatic flags_t mask_flags(input logic [BUS_W-1:0] m);
        flags_t f;
        f.fe   = m[POS_FE];
        f.ore  = m[POS_ORE];
        f.rxne = m[POS_RXNE];
        f.tc   = m[POS_TC];
        f.txe  = m[POS_TXE];
        f.rdy  = m[POS_RDY];
        return f;
    endfunction

endpackage

// File: rtl/uart_status_regif.sv
// Bus decoder: holds the control register and turns word accesses into
// one-cycle strobes; builds the read data. Assumes one access per cycle.
module uart_status_regif
    import uart_status_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  flags_t            flags,
    input  logic [CHAR_W-1:0] rx_q,
    input  logic [CHAR_W-1:0] tx_q,
    output ctrl_t             ctrl,
    output flags_t            clr_mask,
    output logic              flush,
    output logic              wr_txd,
    output logic              rd_rxd
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic hit_ctrl, hit_stat, hit_clr, hit_req, hit_rxd, hit_txd;

    // Address match for each mapped offset.
    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        hit_clr  = (bus_addr == ADDR_W'(OFF_CLR));
        hit_req  = (bus_addr == ADDR_W'(OFF_REQ));
        hit_rxd  = (bus_addr == ADDR_W'(OFF_RXD));
        hit_txd  = (bus_addr == ADDR_W'(OFF_TXD));
    end

    // Write and read strobes toward the flag logic.
    always_comb begin
        clr_mask = (bus_wr && hit_clr) ? mask_flags(bus_wdata) : '0;
        flush    = bus_wr && hit_req && bus_wdata[POS_FLUSH];
        wr_txd   = bus_wr && hit_txd;
        rd_rxd   = bus_rd && hit_rxd;
    end

    // Control register, loaded by a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (bus_wr && hit_ctrl)
            ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Read mux; clear, request and unmapped offsets read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_ctrl)      bus_rdata = BUS_W'(ctrl);
            else if (hit_stat) bus_rdata = stat_word(flags);
            else if (hit_rxd)  bus_rdata = BUS_W'(rx_q);
            else if (hit_txd)  bus_rdata = BUS_W'(tx_q);
        end
    end

endmodule

// File: rtl/uart_status_flags.sv
// Status flags and data registers: accepts received characters, applies
// clear, flush and read side effects, and issues the transmit start.
// Assumes strobes are one cycle wide; a set beats a clear in the same cycle.
module uart_status_flags
    import uart_status_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_frame_err,
    input  logic              tx_done,
    input  flags_t            clr_mask,
    input  logic              flush,
    input  logic              wr_txd,
    input  logic              rd_rxd,
    input  logic [CHAR_W-1:0] txd_wdata,
    output flags_t            flags,
    output logic [CHAR_W-1:0] rx_q,
    output logic [CHAR_W-1:0] tx_q,
    output logic              tx_start
);

    logic accept, overrun, load;

    // Classify an incoming character: dropped, overrun or stored.
    always_comb begin
        accept  = rx_valid && ctrl.port_en && ctrl.rx_en;
        overrun = accept && !ctrl.ovr_dis && flags.rxne;
        load    = accept && !overrun;
    end

    // Flag state: clears first, sets override them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= FLAGS_RESET;
        end else begin
            flags.fe   <= (flags.fe  && !clr_mask.fe)  || (load && rx_frame_err);
            flags.ore  <= (flags.ore && !clr_mask.ore) || overrun;
            flags.rxne <= (flags.rxne && !clr_mask.rxne && !rd_rxd && !flush) || load;
            flags.tc   <= (flags.tc  && !clr_mask.tc)  || tx_done;
            flags.txe  <= (flags.txe && !clr_mask.txe && !wr_txd) || tx_done;
            flags.rdy  <= flags.rdy && !clr_mask.rdy;
        end
    end

    // Data registers and the transmit start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= '0;
            tx_q     <= '0;
            tx_start <= 1'b0;
        end else begin
            if (load)
                rx_q <= rx_char;
            if (wr_txd)
                tx_q <= txd_wdata;
            tx_start <= wr_txd && ctrl.tx_en;
        end
    end

endmodule

// File: rtl/uart_status_irq_comb.sv
// Interrupt combiner: ORs each flag gated by its enable. Purely
// combinational so the line follows the flags in the same cycle.
module uart_status_irq_comb
    import uart_status_pkg::*;
(
    input  flags_t flags,
    input  ctrl_t  ctrl,
    output logic   irq
);

    // Overrun has two enables; framing error only the error enable.
    always_comb begin
        irq = (flags.rxne && ctrl.rxne_ie)
           || (flags.txe  && ctrl.txe_ie)
           || (flags.tc   && ctrl.tc_ie)
           || (flags.ore  && (ctrl.rxne_ie || ctrl.err_ie))
           || (flags.fe   && ctrl.err_ie);
    end

endmodule

// File: rtl/uart_status_irq.sv
// Top: serial-port status and interrupt registers. Assumes a one-cycle
// word bus and single-cycle strobes from the serializer and deserializer.
module uart_status_irq
    import uart_status_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_frame_err,
    output logic              tx_start,
    output logic [CHAR_W-1:0] tx_char,
    input  logic              tx_done,
    output logic              irq
);

    ctrl_t             ctrl;
    flags_t            flags;
    flags_t            clr_mask;
    logic              flush, wr_txd, rd_rxd;
    logic [CHAR_W-1:0] rx_q;

    uart_status_regif #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flags(flags), .rx_q(rx_q), .tx_q(tx_char),
        .ctrl(ctrl), .clr_mask(clr_mask), .flush(flush),
        .wr_txd(wr_txd), .rd_rxd(rd_rxd)
    );

    uart_status_flags #(.CHAR_W(CHAR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_frame_err(rx_frame_err),
        .tx_done(tx_done), .clr_mask(clr_mask), .flush(flush),
        .wr_txd(wr_txd), .rd_rxd(rd_rxd), .txd_wdata(bus_wdata[CHAR_W-1:0]),
        .flags(flags), .rx_q(rx_q), .tx_q(tx_char), .tx_start(tx_start)
    );

    uart_status_irq_comb u_irq (
        .flags(flags), .ctrl(ctrl), .irq(irq)
    );

endmodule

// File: rtl/uart_status_irq_chk.sv
// Checker bound to the top: temporal properties over ports and the
// control and flag state. Assumes the input rules given in the brief.
module uart_status_irq_chk
    import uart_status_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic              tx_done,
    input logic              tx_start,
    input logic              irq,
    input ctrl_t             ctrl,
    input flags_t            flags,
    input logic [CHAR_W-1:0] rx_q
);

    a_r1_rx_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !(ctrl.port_en && ctrl.rx_en) && !bus_wr && !bus_rd && !tx_done
        |=> $stable(flags) && $stable(rx_q));

    a_r2_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && ctrl.port_en && ctrl.rx_en && !ctrl.ovr_dis && flags.rxne
        |=> flags.ore && $stable(rx_q));

    a_r3_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && ctrl.port_en && ctrl.rx_en && ctrl.ovr_dis && !flags.ore
        |=> flags.rxne && !flags.ore && rx_q == $past(rx_char));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == ADDR_W'(OFF_RXD) && !rx_valid
        |=> !flags.rxne);

    a_r5_start_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_TXD) && ctrl.tx_en));

    a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !bus_wr |=> flags.txe && flags.tc);

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.fe || flags.ore || flags.rxne || flags.tc || flags.txe) |-> !irq);

    a_r8_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        flags.fe && ctrl.err_ie |-> irq);

endmodule

bind uart_status_irq uart_status_irq_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .rx_valid(rx_valid), .rx_char(rx_char),
    .tx_done(tx_done), .tx_start(tx_start), .irq(irq),
    .ctrl(ctrl), .flags(flags), .rx_q(rx_q)
);

// File: tb/test_uart_status_irq.sv
// Scoreboard bench: driver tasks queue expected read data and transmit
// characters; monitors pop and compare when the design produces them.
module test_uart_status_irq;

    localparam int ADDR_W = 8;
    localparam int CHAR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rx_valid = 1'b0, rx_frame_err = 1'b0, tx_done = 1'b0;
    logic [CHAR_W-1:0] rx_char = '0;
    logic              tx_start, irq;
    logic [CHAR_W-1:0] tx_char;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0]       rd_exp_q[$];
    string             rd_tag_q[$];
    logic [CHAR_W-1:0] tx_exp_q[$];

    always #2.5 clk = ~clk;

    uart_status_irq #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) i_uart_status_irq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_frame_err(rx_frame_err),
        .tx_start(tx_start), .tx_char(tx_char), .tx_done(tx_done), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the queued expectation.
    always @(negedge clk) begin
        if (bus_rd) begin
            if (rd_exp_q.size() == 0) begin
                check(0, "read without expectation", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    // Monitor: every start pulse must match a queued character.
    always @(negedge clk) begin
        if (tx_start) begin
            if (tx_exp_q.size() == 0) begin
                check(0, "R5 unexpected tx_start", 32'(tx_char), 32'h0);
            end else begin
                logic [CHAR_W-1:0] e;
                e = tx_exp_q.pop_front();
                check(tx_char === e, "R5 tx_char", 32'(tx_char), 32'(e));
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [CHAR_W-1:0] c, input logic ferr);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_char = c; rx_frame_err = ferr;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_frame_err = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1;
        tx_done = 1'b1;
        @(posedge clk); #1;
        tx_done = 1'b0;
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        check(irq === exp, tag, 32'(irq), 32'(exp));
    endtask

    // Offsets and status values used below.
    localparam logic [7:0] CTRL = 8'h00, STAT = 8'h04, CLR = 8'h08,
                           REQ = 8'h0C, RXD = 8'h10, TXD = 8'h14;
    localparam logic [31:0] S0 = 32'h0200_00C0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        bus_read(STAT, S0, "R9 status reset");
        bus_read(CTRL, 32'h0, "R9 control reset");
        bus_read(RXD, 32'h0, "R9 rx data reset");
        expect_irq(1'b0, "R9 irq reset");

        // R1 receive gated by both enables
        send_rx(9'h1A5, 1'b0);
        bus_read(STAT, S0, "R1 dropped with no enables");
        bus_write(CTRL, 32'h01);
        send_rx(9'h1A5, 1'b0);
        bus_write(CTRL, 32'h02);
        send_rx(9'h1A5, 1'b0);
        bus_read(STAT, S0, "R1 dropped with one enable");
        bus_read(RXD, 32'h0, "R1 data untouched");

        // R4 and R8 receive path
        bus_write(CTRL, 32'h03);
        send_rx(9'h155, 1'b0);
        bus_read(STAT, 32'h0200_00E0, "R4 rxne set");
        expect_irq(1'b0, "R8 no enable no irq");
        bus_write(CTRL, 32'h0B);
        expect_irq(1'b1, "R8 rxne irq");
        bus_read(RXD, 32'h155, "R4 nine-bit read");
        expect_irq(1'b0, "R8 irq drops after read");
        bus_read(STAT, S0, "R4 rxne cleared by read");

        // R2 overrun keeps first character
        send_rx(9'h011, 1'b0);
        send_rx(9'h022, 1'b0);
        bus_read(STAT, 32'h0200_00E8, "R2 overrun flag");
        bus_read(RXD, 32'h011, "R2 earlier data kept");
        expect_irq(1'b1, "R8 overrun via rxne enable");
        bus_write(CTRL, 32'h43);
        expect_irq(1'b1, "R8 overrun via error enable");
        bus_write(CTRL, 32'h03);
        expect_irq(1'b0, "R8 overrun no enable");
        bus_write(CTRL, 32'h43);
        bus_write(CLR, 32'h08);
        expect_irq(1'b0, "R8 irq falls with clear");
        bus_read(STAT, S0, "R6 overrun cleared");

        // R3 overrun disabled
        bus_write(CTRL, 32'h83);
        send_rx(9'h033, 1'b0);
        send_rx(9'h044, 1'b0);
        bus_read(STAT, 32'h0200_00E0, "R3 no overrun");
        bus_read(RXD, 32'h044, "R3 overwritten");

        // R6 zero bits keep, R7 flush and zero reads
        send_rx(9'h0F0, 1'b0);
        bus_write(CLR, 32'h0);
        bus_read(STAT, 32'h0200_00E0, "R6 zero mask keeps");
        bus_write(REQ, 32'h08);
        bus_read(STAT, S0, "R7 flush clears rxne");
        bus_read(REQ, 32'h0, "R7 request reads zero");
        bus_read(CLR, 32'h0, "R7 clear reads zero");

        // R8 framing error uses only the error enable
        bus_write(CTRL, 32'h03);
        send_rx(9'h07E, 1'b1);
        bus_read(STAT, 32'h0200_00E2, "R8 framing flag");
        bus_write(REQ, 32'h08);
        bus_write(CTRL, 32'h0B);
        expect_irq(1'b0, "R8 framing ignores rxne enable");
        bus_write(CTRL, 32'h43);
        expect_irq(1'b1, "R8 framing with error enable");
        bus_write(CLR, 32'h02);
        expect_irq(1'b0, "R8 framing cleared");

        // R5 transmit
        bus_write(CTRL, 32'h05);
        bus_write(CLR, 32'h40);
        bus_read(STAT, 32'h0200_0080, "R6 tc cleared");
        tx_exp_q.push_back(9'h1C3);
        bus_write(TXD, 32'h1C3);
        bus_read(STAT, 32'h0200_0000, "R5 txe cleared");
        bus_write(CTRL, 32'h35);
        expect_irq(1'b0, "R8 transmit busy");
        pulse_done();
        bus_read(STAT, S0, "R5 done sets txe tc");
        expect_irq(1'b1, "R8 transmit irq");
        bus_read(TXD, 32'h1C3, "R5 tx data readback");
        bus_write(CTRL, 32'h01);
        bus_write(TXD, 32'h0AA);
        bus_read(STAT, 32'h0200_0040, "R5 no start without enable");
        pulse_done();

        // R10 read-only offsets, R11 unmapped
        bus_write(STAT, 32'h0);
        bus_read(STAT, S0, "R10 status write ignored");
        bus_write(RXD, 32'h1FF);
        bus_read(RXD, 32'h07E, "R10 rx data write ignored");
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(CTRL, 32'h01, "R11 unmapped write");
        bus_read(STAT, S0, "R11 unmapped write status");
        bus_read(8'h20, 32'h0, "R11 unmapped read");
        bus_read(8'h06, 32'h0, "R11 unaligned read");

        // R6 another bit position
        bus_write(CLR, 32'h0200_0000);
        bus_read(STAT, 32'h0000_00C0, "R6 ready bit cleared");

        repeat (3) @(posedge clk);
        check(tx_exp_q.size() == 0, "R5 all starts seen", 32'(tx_exp_q.size()), 32'h0);
        check(rd_exp_q.size() == 0, "all reads compared", 32'(rd_exp_q.size()), 32'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5ns * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule